// File: doc/BRIEF.md
# Link-Layer Transmit Framer with Retransmission

This block is the transmit half of a packet data link layer. An upstream transaction layer hands it one packet at a time as a byte stream: a 12- or 16-byte header, 0 or more payload bytes and an optional 4-byte end-to-end CRC. All of these are carried as opaque body bytes. The block gives each packet a 12-bit sequence number and stores it in a replay buffer. It then emits a frame on a byte-wide output. The frame is a start control byte, a two-byte sequence field, the body, a 32-bit link CRC over the sequence field and body, and an end control byte. Control bytes are marked by a sideband flag.

The far end returns acknowledgement traffic carrying a sequence number. A positive acknowledgement frees every stored packet up to and including that number. A negative acknowledgement frees the same packets and then resends all remaining stored packets, oldest first, with their original numbers and contents, without any upstream involvement. New input is held off while a retransmission runs or while the buffer is full.

Top module: `dll_tx_framer`

## Requirements
- R1: While and after reset, with no input, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: A frame appears on consecutive cycles with `out_valid_o` high. It is: control byte 0xFB with `out_ctrl_o`=1; byte {4'b0000, seq[11:8]}; byte seq[7:0]; the body bytes; four link CRC bytes; control byte 0xFD with `out_ctrl_o`=1. `out_ctrl_o` is 0 on every other byte, and `out_valid_o` is low for at least one cycle after each end byte.
- R3: The link CRC uses polynomial 0x04C11DB7, without reflection, each byte applied bit 7 first. The register starts at all ones and the result is inverted. The CRC covers the two sequence bytes and the body, and is sent most significant byte first.
- R4: The first packet accepted after reset gets sequence number 0, and each further packet gets the next number modulo 4096 (4095 is followed by 0).
- R5: Body bytes are forwarded unchanged and in order. The body length is 12 to MAX_BYTES bytes, and `in_last_i` marks the final byte.
- R6: Feedback with `fb_nak_i`=0 and number N frees the stored packets from the oldest through N. If (N+1-oldest) mod 4096 exceeds the number of stored packets, the feedback is ignored.
- R7: Feedback with `fb_nak_i`=1 and number N frees the same packets as R6. It then retransmits every remaining stored packet, oldest first, with unchanged sequence number and body. N equal to the oldest number minus one retransmits them all.
- R8: `in_ready_o` is 0 while SLOTS packets are stored. It is also 0 from the cycle after an accepted negative acknowledgement that leaves packets stored, until the last retransmitted frame is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input body byte valid |
| in_data_i | input | 8 | Input body byte |
| in_last_i | input | 1 | Final byte of the packet |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| fb_valid_i | input | 1 | Acknowledgement feedback strobe |
| fb_nak_i | input | 1 | 1 = negative acknowledgement, 0 = positive |
| fb_seq_i | input | 12 | Sequence number carried by the feedback |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ctrl_o | output | 1 | Output byte is a framing control byte |

## Verification
On every cycle the checker tests the shape of the frame edges. A start byte must be followed by a data byte with a zero upper nibble. An end byte must be followed by an idle cycle. A frame may end only on an end byte. Only the two framing codes may carry the control flag, and the count of stored packets never exceeds the buffer depth. The directed scenarios cover the rest. They check the CRC value, the sequence order and its wrap, byte-exact body pass-through at minimum and maximum length, and the release counts after positive, stale and negative feedback. They also check that retransmitted frames come in the right order and that input is held off during replay.

// File: rtl/dll_tx_pkg.sv
package dll_tx_pkg;
  localparam int unsigned SEQ_W = 12;
  localparam logic [31:0] LCRC_POLY = 32'h04C1_1DB7;

  typedef enum logic [2:0] {
    EM_IDLE, EM_SOF, EM_SQH, EM_SQL, EM_BODY, EM_CRC, EM_EOF
  } em_state_e;

  // one byte into the running link CRC, bit 7 first
  function automatic logic [31:0] lcrc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ LCRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/dll_tx_replay_buf.sv
module dll_tx_replay_buf
  import dll_tx_pkg::*;
#(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_BYTES = 64,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned PTR_W    = SLOT_W + 1,
  localparam int unsigned IDX_W    = $clog2(MAX_BYTES),
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_last_i,
  output logic              wr_ready_o,
  input  logic              fb_valid_i,
  input  logic              fb_nak_i,
  input  logic [SEQ_W-1:0]  fb_seq_i,
  output logic              pend_o,
  input  logic              start_i,
  output logic [SLOT_W-1:0] head_slot_o,
  output logic [SEQ_W-1:0]  head_seq_o,
  output logic [LEN_W-1:0]  head_len_o,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_byte_o,
  input  logic              busy_i,
  output logic [PTR_W-1:0]  held_o
);
  logic [7:0]       mem_q [SLOTS][MAX_BYTES];
  logic [LEN_W-1:0] len_q [SLOTS];
  logic [SEQ_W-1:0] seq_q [SLOTS];

  logic [PTR_W-1:0] wr_ptr_q, ack_ptr_q, snd_ptr_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [SEQ_W-1:0] next_seq_q, old_seq_q;
  logic             replay_q;

  logic [PTR_W-1:0] held, sent, rel_p, ack_new;
  logic [SEQ_W-1:0] rel;
  logic             full, wr_fire, fb_ok;
  logic [SLOT_W-1:0] wr_slot;

  assign held    = wr_ptr_q - ack_ptr_q;
  assign sent    = snd_ptr_q - ack_ptr_q;
  assign full    = (held == PTR_W'(SLOTS));
  assign wr_ready_o = !full && !replay_q;
  assign wr_fire = wr_valid_i && wr_ready_o;
  assign wr_slot = wr_ptr_q[SLOT_W-1:0];

  // number of packets released by the feedback
  assign rel     = fb_seq_i + SEQ_W'(1) - old_seq_q;
  assign fb_ok   = fb_valid_i && (rel <= SEQ_W'(held));
  assign rel_p   = PTR_W'(rel);
  assign ack_new = ack_ptr_q + rel_p;

  assign pend_o      = (snd_ptr_q != wr_ptr_q) && !fb_valid_i;
  assign head_slot_o = snd_ptr_q[SLOT_W-1:0];
  assign head_seq_o  = seq_q[snd_ptr_q[SLOT_W-1:0]];
  assign head_len_o  = len_q[snd_ptr_q[SLOT_W-1:0]];
  assign rd_byte_o   = mem_q[rd_slot_i][rd_idx_i];
  assign held_o      = held;

  always_ff @(posedge clk_i) begin
    if (wr_fire) begin
      mem_q[wr_slot][wr_idx_q] <= wr_data_i;
      if (wr_last_i) begin
        len_q[wr_slot] <= LEN_W'(wr_idx_q) + LEN_W'(1);
        seq_q[wr_slot] <= next_seq_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      ack_ptr_q  <= '0;
      snd_ptr_q  <= '0;
      wr_idx_q   <= '0;
      next_seq_q <= '0;
      old_seq_q  <= '0;
      replay_q   <= 1'b0;
    end else begin
      if (wr_fire) begin
        if (wr_last_i) begin
          wr_idx_q   <= '0;
          wr_ptr_q   <= wr_ptr_q + PTR_W'(1);
          next_seq_q <= next_seq_q + SEQ_W'(1);
        end else if (wr_idx_q != IDX_W'(MAX_BYTES - 1)) begin
          wr_idx_q <= wr_idx_q + IDX_W'(1);
        end
      end
      if (fb_ok) begin
        ack_ptr_q <= ack_new;
        old_seq_q <= old_seq_q + rel;
        if (fb_nak_i) begin
          snd_ptr_q <= ack_new;
          replay_q  <= (held != rel_p);
        end else if (rel_p > sent) begin
          snd_ptr_q <= ack_new;
        end
      end else begin
        if (start_i) snd_ptr_q <= snd_ptr_q + PTR_W'(1);
        if (replay_q && (snd_ptr_q == wr_ptr_q) && !busy_i) replay_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dll_tx_emitter.sv
module dll_tx_emitter
  import dll_tx_pkg::*;
#(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_BYTES = 64,
  parameter logic [7:0]  SOF_CODE  = 8'hFB,
  parameter logic [7:0]  EOF_CODE  = 8'hFD,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned IDX_W    = $clog2(MAX_BYTES),
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  output logic              start_o,
  input  logic [SLOT_W-1:0] head_slot_i,
  input  logic [SEQ_W-1:0]  head_seq_i,
  input  logic [LEN_W-1:0]  head_len_i,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [7:0]        rd_byte_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_ctrl_o
);
  em_state_e         st_q, st_d;
  logic [SLOT_W-1:0] slot_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [31:0]       crc_q, crc_d, crc_fin;
  logic              byte_v, byte_c;
  logic [7:0]        byte_d;

  assign start_o   = (st_q == EM_IDLE) && pend_i;
  assign busy_o    = (st_q != EM_IDLE);
  assign rd_slot_o = slot_q;
  assign rd_idx_o  = idx_q;
  assign crc_fin   = ~crc_q;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    crc_d  = crc_q;
    byte_v = 1'b0;
    byte_c = 1'b0;
    byte_d = '0;
    unique case (st_q)
      EM_IDLE: if (pend_i) st_d = EM_SOF;
      EM_SOF: begin
        byte_v = 1'b1; byte_c = 1'b1; byte_d = SOF_CODE;
        crc_d  = '1;
        st_d   = EM_SQH;
      end
      EM_SQH: begin
        byte_v = 1'b1; byte_d = {4'h0, seq_q[SEQ_W-1:8]};
        crc_d  = lcrc_byte(crc_q, byte_d);
        st_d   = EM_SQL;
      end
      EM_SQL: begin
        byte_v = 1'b1; byte_d = seq_q[7:0];
        crc_d  = lcrc_byte(crc_q, byte_d);
        idx_d  = '0;
        st_d   = EM_BODY;
      end
      EM_BODY: begin
        byte_v = 1'b1; byte_d = rd_byte_i;
        crc_d  = lcrc_byte(crc_q, byte_d);
        if ((LEN_W'(idx_q) + LEN_W'(1)) == len_q) begin
          cnt_d = '0;
          st_d  = EM_CRC;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      EM_CRC: begin
        byte_v = 1'b1; byte_d = crc_fin[8*(3-cnt_q) +: 8];
        cnt_d  = cnt_q + 2'd1;
        if (cnt_q == 2'd3) st_d = EM_EOF;
      end
      EM_EOF: begin
        byte_v = 1'b1; byte_c = 1'b1; byte_d = EOF_CODE;
        st_d   = EM_IDLE;
      end
      default: st_d = EM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= EM_IDLE;
      slot_q      <= '0;
      seq_q       <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      cnt_q       <= '0;
      crc_q       <= '1;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_ctrl_o  <= 1'b0;
    end else begin
      st_q        <= st_d;
      idx_q       <= idx_d;
      cnt_q       <= cnt_d;
      crc_q       <= crc_d;
      out_valid_o <= byte_v;
      out_data_o  <= byte_d;
      out_ctrl_o  <= byte_c;
      if (start_o) begin
        slot_q <= head_slot_i;
        seq_q  <= head_seq_i;
        len_q  <= head_len_i;
      end
    end
  end
endmodule

// File: rtl/dll_tx_framer.sv
module dll_tx_framer
  import dll_tx_pkg::*;
#(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_BYTES = 64,
  parameter logic [7:0]  SOF_CODE  = 8'hFB,
  parameter logic [7:0]  EOF_CODE  = 8'hFD
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        in_ready_o,
  input  logic        fb_valid_i,
  input  logic        fb_nak_i,
  input  logic [11:0] fb_seq_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_ctrl_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned PTR_W  = SLOT_W + 1;
  localparam int unsigned IDX_W  = $clog2(MAX_BYTES);
  localparam int unsigned LEN_W  = $clog2(MAX_BYTES + 1);

  logic              pend, start, busy;
  logic [SLOT_W-1:0] head_slot, rd_slot;
  logic [SEQ_W-1:0]  head_seq;
  logic [LEN_W-1:0]  head_len;
  logic [IDX_W-1:0]  rd_idx;
  logic [7:0]        rd_byte;
  logic [PTR_W-1:0]  buf_held;

  dll_tx_replay_buf #(.SLOTS(SLOTS), .MAX_BYTES(MAX_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .wr_valid_i (in_valid_i), .wr_data_i (in_data_i), .wr_last_i (in_last_i),
    .wr_ready_o (in_ready_o),
    .fb_valid_i, .fb_nak_i, .fb_seq_i,
    .pend_o (pend), .start_i (start),
    .head_slot_o (head_slot), .head_seq_o (head_seq), .head_len_o (head_len),
    .rd_slot_i (rd_slot), .rd_idx_i (rd_idx), .rd_byte_o (rd_byte),
    .busy_i (busy), .held_o (buf_held)
  );

  dll_tx_emitter #(.SLOTS(SLOTS), .MAX_BYTES(MAX_BYTES),
                   .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE)) u_emit (
    .clk_i, .rst_ni,
    .pend_i (pend), .start_o (start),
    .head_slot_i (head_slot), .head_seq_i (head_seq), .head_len_i (head_len),
    .rd_slot_o (rd_slot), .rd_idx_o (rd_idx), .rd_byte_i (rd_byte),
    .busy_o (busy),
    .out_valid_o, .out_data_o, .out_ctrl_o
  );
endmodule

// File: rtl/dll_tx_framer_chk.sv
module dll_tx_framer_chk #(
  parameter int unsigned SLOTS    = 4,
  parameter logic [7:0]  SOF_CODE = 8'hFB,
  parameter logic [7:0]  EOF_CODE = 8'hFD,
  localparam int unsigned PTR_W   = $clog2(SLOTS) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             out_valid_o,
  input logic [7:0]       out_data_o,
  input logic             out_ctrl_o,
  input logic [PTR_W-1:0] held_i
);
  // R2
  sof_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ctrl_o && out_data_o == SOF_CODE)
      |=> (out_valid_o && !out_ctrl_o && out_data_o[7:4] == 4'h0));

  // R2
  eof_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ctrl_o && out_data_o == EOF_CODE) |=> !out_valid_o);

  // R2
  frame_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_ctrl_o));

  // R2
  ctrl_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ctrl_o) |-> (out_data_o == SOF_CODE || out_data_o == EOF_CODE));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i <= PTR_W'(SLOTS));
endmodule

bind dll_tx_framer dll_tx_framer_chk #(.SLOTS(SLOTS), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni),
  .out_valid_o (out_valid_o), .out_data_o (out_data_o), .out_ctrl_o (out_ctrl_o),
  .held_i (buf_held)
);

// File: tb/tb_dll_tx_framer.sv
`timescale 1ns/1ps
module tb_dll_tx_framer;
  localparam int SLOTS = 4;
  localparam int MAXB  = 64;
  localparam logic [7:0] SOF = 8'hFB;
  localparam logic [7:0] EOF = 8'hFD;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_last_i = 1'b0, in_ready_o;
  logic [7:0] in_data_i = '0;
  logic fb_valid_i = 1'b0, fb_nak_i = 1'b0;
  logic [11:0] fb_seq_i = '0;
  logic out_valid_o, out_ctrl_o;
  logic [7:0] out_data_o;

  int n_chk = 0, n_bad = 0;
  int mon_seq[$], mon_len[$], mon_b0[$];
  logic [7:0] fb[$];
  bit in_frame = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dll_tx_framer #(.SLOTS(SLOTS), .MAX_BYTES(MAXB)) dut (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_data_i, .in_last_i, .in_ready_o,
    .fb_valid_i, .fb_nak_i, .fb_seq_i, .out_valid_o, .out_data_o, .out_ctrl_o);

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic top = r[31] ^ d[b];
      r = r << 1;
      if (top) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic close_frame();
    int n = fb.size();
    logic [31:0] c = 32'hFFFF_FFFF, got;
    bit body_ok = 1;
    if (n < 18) begin
      check(0, "R2", "frame too short", n, 18);
      return;
    end
    for (int i = 0; i < n - 4; i++) c = ref_crc(c, fb[i]);
    c = ~c;
    got = {fb[n-4], fb[n-3], fb[n-2], fb[n-1]};
    check(got == c, "R3", "link crc", got, c);
    check(fb[0][7:4] == 4'h0, "R2", "sequence pad nibble", fb[0][7:4], 0);
    for (int j = 0; j < n - 6; j++)
      if (fb[2+j] != 8'(fb[2] + j)) body_ok = 0;
    check(body_ok, "R5", "body bytes unchanged", body_ok, 1);
    mon_seq.push_back({fb[0][3:0], fb[1]});
    mon_len.push_back(n - 6);
    mon_b0.push_back(fb[2]);
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid_o) begin
        if (out_ctrl_o) begin
          if (out_data_o == SOF) begin fb.delete(); in_frame = 1; end
          else if (out_data_o == EOF) begin if (in_frame) close_frame(); in_frame = 0; end
          else check(0, "R2", "stray control byte", out_data_o, SOF);
        end else if (in_frame) fb.push_back(out_data_o);
        else check(0, "R2", "data outside frame", out_data_o, 0);
      end else if (in_frame) check(0, "R2", "gap inside frame", 0, 1);
    end
  end

  task automatic push_pkt(int len, logic [7:0] b0);
    for (int j = 0; j < len; j++) begin
      in_valid_i = 1'b1; in_data_i = 8'(b0 + j); in_last_i = (j == len - 1);
      while (!in_ready_o) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic send_fb(bit nak, int seq);
    fb_valid_i = 1'b1; fb_nak_i = nak; fb_seq_i = 12'(seq);
    @(negedge clk);
    fb_valid_i = 1'b0; fb_nak_i = 1'b0;
  endtask

  task automatic wait_frames(int n);
    int t = 0;
    while (mon_seq.size() < n && t < 20000) begin @(negedge clk); t++; end
    check(mon_seq.size() >= n, "R2", "frame count", mon_seq.size(), n);
  endtask

  task automatic expect_frame(int k, int seq, int len, int b0, string req);
    if (k >= mon_seq.size()) begin
      check(0, req, "missing frame", mon_seq.size(), k + 1);
      return;
    end
    check(mon_seq[k] == seq, req, "sequence number", mon_seq[k], seq);
    check(mon_len[k] == len, req, "body length", mon_len[k], len);
    check(mon_b0[k] == b0, req, "first body byte", mon_b0[k], b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid_o == 0, "R1", "out_valid in reset", out_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk); @(negedge clk);
    check(out_valid_o == 0, "R1", "out_valid after reset", out_valid_o, 0);
    check(in_ready_o == 1, "R1", "in_ready after reset", in_ready_o, 1);
  endtask

  task automatic t_basic();
    push_pkt(12, 8'h10); push_pkt(16, 8'h40); push_pkt(20, 8'h80);
    wait_frames(3);
    expect_frame(0, 0, 12, 8'h10, "R4");
    expect_frame(1, 1, 16, 8'h40, "R4");
    expect_frame(2, 2, 20, 8'h80, "R5");
    send_fb(0, 2);
  endtask

  task automatic t_full_ack();
    for (int p = 0; p < 4; p++) push_pkt(12, 8'(8'h20 + 16 * p));
    check(in_ready_o == 0, "R8", "ready while buffer full", in_ready_o, 0);
    wait_frames(7);
    expect_frame(6, 6, 12, 8'h50, "R4");
    send_fb(0, 200);
    check(in_ready_o == 0, "R6", "stale ack ignored", in_ready_o, 0);
    send_fb(0, 4);
    check(in_ready_o == 1, "R6", "ready after ack of two", in_ready_o, 1);
    push_pkt(12, 8'hA0); push_pkt(12, 8'hB0);
    check(in_ready_o == 0, "R6", "exactly two slots freed", in_ready_o, 0);
    wait_frames(9);
    expect_frame(8, 8, 12, 8'hB0, "R4");
  endtask

  task automatic t_nak();
    send_fb(1, 6);
    check(in_ready_o == 0, "R8", "ready low during replay", in_ready_o, 0);
    wait_frames(11);
    expect_frame(9, 7, 12, 8'hA0, "R7");
    expect_frame(10, 8, 12, 8'hB0, "R7");
    @(negedge clk); @(negedge clk);
    check(in_ready_o == 1, "R8", "ready after replay", in_ready_o, 1);
    send_fb(1, 6);
    wait_frames(13);
    expect_frame(11, 7, 12, 8'hA0, "R7");
    expect_frame(12, 8, 12, 8'hB0, "R7");
    @(negedge clk); @(negedge clk);
    send_fb(0, 8);
    check(in_ready_o == 1, "R6", "ready after final ack", in_ready_o, 1);
  endtask

  task automatic t_lengths();
    push_pkt(12, 8'hF8);
    push_pkt(MAXB, 8'h00);
    wait_frames(15);
    expect_frame(13, 9, 12, 8'hF8, "R5");
    expect_frame(14, 10, MAXB, 8'h00, "R5");
    send_fb(0, 10);
  endtask

  task automatic t_wrap();
    int base = mon_seq.size();
    int cnt = 4087;
    int order_err = 0;
    fork
      for (int p = 0; p < cnt; p++) push_pkt(12, 8'(p));
      begin
        int k = base;
        int t = 0;
        while (k < base + cnt && t < 150000) begin
          if (mon_seq.size() > k) begin send_fb(0, mon_seq[k]); k++; end
          else begin @(negedge clk); t++; end
        end
      end
    join
    check(mon_seq.size() == base + cnt, "R4", "wrap frame count", mon_seq.size(), base + cnt);
    for (int k = 0; k < cnt && base + k < mon_seq.size(); k++)
      if (mon_seq[base + k] != ((11 + k) % 4096)) order_err++;
    check(order_err == 0, "R4", "sequence order across wrap", order_err, 0);
    if (mon_seq.size() == base + cnt) begin
      check(mon_seq[base + cnt - 3] == 4095, "R4", "last before wrap", mon_seq[base + cnt - 3], 4095);
      check(mon_seq[base + cnt - 2] == 0, "R4", "wrap to zero", mon_seq[base + cnt - 2], 0);
      check(mon_seq[base + cnt - 1] == 1, "R4", "after wrap", mon_seq[base + cnt - 1], 1);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_full_ack();
    t_nak();
    t_lengths();
    t_wrap();
    repeat (5) @(negedge clk);
    done = 1;
    summary();
  end
endmodule